// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block is a bus master that moves an operand of one to four bytes between the core and a 32-bit external data bus. The device on the far side may be 8, 16 or 32 bits wide. It reports its width in every bus cycle on two acknowledge lines. The sequencer does not know the port width in advance. It starts each cycle with the full remaining size and the current address. When the port has taken what it can, the sequencer re-issues the leftover bytes with a new size code and a higher address. It repeats this until every byte has been moved.

On a write, the lane multiplexer copies operand bytes onto several lanes. This lets an 8-bit, 16-bit or 32-bit port each find the byte it needs on its own lanes. On a read, the sequencer captures only the lanes that hold the requested bytes. It appends them to an operand register that is right-justified. A one-cycle done pulse marks the end of the transfer.

Top module: `bus_size_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `bus_strobe` and `done` are 0.
- R2: `req_size` and `bus_siz` use one encoding of a byte count: 2'b01 = 1, 2'b10 = 2, 2'b11 = 3, 2'b00 = 4. In every bus cycle, `bus_siz` gives the number of operand bytes not yet moved.
- R3: In every bus cycle, `bus_addr` equals the request address plus the number of bytes already moved. It does not change while the strobe is low between two cycles.
- R4: `bus_ack` is decoded as follows: 2'b11 means a 32-bit port, 2'b10 means a 16-bit port, 2'b01 means an 8-bit port. With 2'b00 the cycle is stretched: the strobe, address, size and write lanes all hold.
- R5: A cycle moves min(remaining, W - (address mod W)) bytes, where W is the port width in bytes.
- R6: Lanes are numbered 0 (`bus_dout[31:24]`) to 3 (`bus_dout[7:0]`). On a write, the byte for address a appears on lane a mod W for each of the three widths at once. The operand is taken from the low n bytes of `req_wdata`, and its most significant byte goes to the lowest address.
- R7: On a read, the byte for address a is taken from lane a mod W of `bus_din`, and all other lanes are ignored. `rd_data` holds the n bytes right-justified, with the lowest address in the most significant of them, and zeros above.
- R8: `bus_strobe` rises in the cycle after a request is accepted. It falls in the cycle after each acknowledge and, if bytes remain, rises again one cycle later.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge. A read result is valid on `rd_data` at that pulse and held until the next request.
- R10: A request presented while a transfer is in progress is ignored.
- R11: `bus_rw` is 1 for a read and 0 for a write, and it is steady for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand byte count code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_siz | output | 2 | Remaining byte count code |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack | input | 2 | Port width acknowledge |
| rd_data | output | 32 | Read operand, right-justified |
| done | output | 1 | Transfer complete pulse |

## Verification
The strobe is first seen high one cycle after the request edge. Every acknowledge sampled at a clock edge drops the strobe, and with the final acknowledge it raises `done` and updates `rd_data`. All of these are visible one cycle after the acknowledge edge. The next cycle's strobe, address and size follow one cycle later again. The bench drives requests and acknowledges on the falling edge. It checks the new address, size and lanes on the falling edge after the cycle in which they are due, and checks that the done pulse has cleared one falling edge later still. A sweep covers every port width, size, offset and direction, with zero to two wait cycles.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = LANES * BYTE_W;
    localparam int CNT_W  = $clog2(LANES) + 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUS  = 2'd1,
        S_TURN = 2'd2
    } seq_state_e;

    // Byte count (1..4) to the size code placed on the bus.
    function automatic logic [1:0] siz_of_count(logic [CNT_W-1:0] n);
        case (n)
            3'd1:    return 2'b01;
            3'd2:    return 2'b10;
            3'd3:    return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Size code to byte count; code 00 stands for a full long word.
    function automatic logic [CNT_W-1:0] count_of_siz(logic [1:0] s);
        if (s == 2'b00) return CNT_W'(LANES);
        return {1'b0, s};
    endfunction

endpackage

// File: rtl/bsz_ack_decode.sv
module bsz_ack_decode
    import bsz_pkg::*;
(
    input  logic [1:0]       ack,
    input  logic [1:0]       off,
    input  logic [CNT_W-1:0] rem,
    output logic             hit,
    output logic [CNT_W-1:0] acc,
    output logic [1:0]       lane_base
);
    logic [CNT_W-1:0] room;

    always_comb begin
        case (ack)
            2'b11: begin
                room      = CNT_W'(LANES) - {1'b0, off};
                lane_base = off;
            end
            2'b10: begin
                room      = 3'd2 - {2'b00, off[0]};
                lane_base = {1'b0, off[0]};
            end
            2'b01: begin
                room      = 3'd1;
                lane_base = 2'd0;
            end
            default: begin
                room      = '0;
                lane_base = 2'd0;
            end
        endcase
        hit = (ack != 2'b00);
        acc = (rem < room) ? rem : room;
    end

endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer
    import bsz_pkg::*;
(
    input  logic [BUS_W-1:0] wbuf,
    input  logic [1:0]       off,
    output logic [BUS_W-1:0] dout
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [1:0] src;

        always_comb begin
            if (2'(k) >= off) begin
                src = 2'(k) - off;
            end else if ((k < 2) && (2'(k) >= {1'b0, off[0]})) begin
                src = 2'(k) - {1'b0, off[0]};
            end else begin
                src = 2'd0;
            end
        end

        assign dout[BYTE_W*(LANES-1-k) +: BYTE_W] =
            wbuf[BYTE_W*(LANES-1-int'(src)) +: BYTE_W];
    end

endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge
    import bsz_pkg::*;
(
    input  logic [BUS_W-1:0] din,
    input  logic [1:0]       lane_base,
    input  logic [CNT_W-1:0] acc,
    input  logic [BUS_W-1:0] acc_in,
    output logic [BUS_W-1:0] acc_out
);
    always_comb begin
        logic [1:0] li;
        li      = 2'd0;
        acc_out = acc_in;
        for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) < acc) begin
                li      = lane_base + 2'(i);
                acc_out = {acc_out[BUS_W-BYTE_W-1:0],
                           din[BYTE_W*(LANES-1-int'(li)) +: BYTE_W]};
            end
        end
    end

endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              bus_strobe,
    output logic              bus_rw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic [BUS_W-1:0]  bus_dout,
    input  logic [BUS_W-1:0]  bus_din,
    input  logic [1:0]        bus_ack,
    output logic [BUS_W-1:0]  rd_data,
    output logic              done
);
    localparam int SH_W = CNT_W + $clog2(BYTE_W);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic              wr;
        logic [BUS_W-1:0]  wbuf;
        logic [BUS_W-1:0]  rbuf;
        logic              done;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic             hit_w;
    logic [CNT_W-1:0] acc_w;
    logic [1:0]       lane_base_w;
    logic [BUS_W-1:0] merged_w;
    logic [CNT_W-1:0] req_cnt_w;

    bsz_ack_decode i_ack (
        .ack       (bus_ack),
        .off       (cur_q.addr[1:0]),
        .rem       (cur_q.rem),
        .hit       (hit_w),
        .acc       (acc_w),
        .lane_base (lane_base_w)
    );

    bsz_lane_steer i_steer (
        .wbuf (cur_q.wbuf),
        .off  (cur_q.addr[1:0]),
        .dout (bus_dout)
    );

    bsz_read_merge i_merge (
        .din       (bus_din),
        .lane_base (lane_base_w),
        .acc       (acc_w),
        .acc_in    (cur_q.rbuf),
        .acc_out   (merged_w)
    );

    assign req_cnt_w = count_of_siz(req_size);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    nxt_d.st   = S_BUS;
                    nxt_d.addr = req_addr;
                    nxt_d.rem  = req_cnt_w;
                    nxt_d.wr   = req_write;
                    nxt_d.wbuf = req_wdata << SH_W'({CNT_W'(LANES) - req_cnt_w, 3'b000});
                    nxt_d.rbuf = '0;
                end
            end
            S_BUS: begin
                if (hit_w) begin
                    nxt_d.addr = cur_q.addr + ADDR_W'(acc_w);
                    nxt_d.rem  = cur_q.rem - acc_w;
                    nxt_d.wbuf = cur_q.wbuf << SH_W'({acc_w, 3'b000});
                    if (!cur_q.wr) begin
                        nxt_d.rbuf = merged_w;
                    end
                    if (cur_q.rem == acc_w) begin
                        nxt_d.st   = S_IDLE;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.st = S_TURN;
                    end
                end
            end
            S_TURN: begin
                nxt_d.st = S_BUS;
            end
            default: begin
                nxt_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_strobe = (cur_q.st == S_BUS);
    assign bus_rw     = !cur_q.wr;
    assign bus_addr   = cur_q.addr;
    assign bus_siz    = siz_of_count(cur_q.rem);
    assign rd_data    = cur_q.rbuf;
    assign done       = cur_q.done;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows an acknowledged strobe cycle
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_strobe) && ($past(bus_ack) != 2'b00)));

    // R8: strobe drops after every acknowledge
    p_gap_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && (bus_ack != 2'b00)) |=> !bus_strobe);

    // R8: the gap lasts exactly one cycle
    p_turn_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_TURN) |=> bus_strobe);

    // R4: no acknowledge stretches the cycle unchanged
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && (bus_ack == 2'b00)) |=>
            (bus_strobe && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

    // R5: each acknowledged cycle moves at least one byte and no more than remain
    p_progress_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && hit_w) |-> ((acc_w != '0) && (acc_w <= cur_q.rem)));

    // R3: address and size stay put across the strobe gap
    p_turn_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_TURN) |=> ($stable(bus_addr) && $stable(bus_siz)));

    // R11: direction steady while strobe stays high
    p_rw_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && $past(bus_strobe)) |-> $stable(bus_rw));

endmodule

// File: tb/test_bus_size_seq.sv
`timescale 1ns/1ps
module test_bus_size_seq;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          bus_strobe, bus_rw, done;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_siz;
    logic [31:0]   bus_dout, rd_data;
    logic [31:0]   bus_din = '0;
    logic [1:0]    bus_ack = 2'b00;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_size_seq #(.ADDR_W(AW)) i_bus_size_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .bus_strobe (bus_strobe),
        .bus_rw     (bus_rw),
        .bus_addr   (bus_addr),
        .bus_siz    (bus_siz),
        .bus_dout   (bus_dout),
        .bus_din    (bus_din),
        .bus_ack    (bus_ack),
        .rd_data    (rd_data),
        .done       (done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(int n);
        case (n)
            1:       return 2'b01;
            2:       return 2'b10;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    // pw = port width in bytes (1, 2 or 4)
    task automatic run_xfer(int pw, int n, int off, bit wr, int waits);
        logic [31:0] a, wd, expr, din;
        int r, j, acc, lb;
        a    = 32'h0000_3A40 + off;
        wd   = $urandom();
        expr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = enc(n);
        req_write = wr;   req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        r = n; j = 0;
        while (r > 0) begin
            chk("R8",  "strobe high", {31'd0, bus_strobe}, 32'd1);
            chk("R2",  "size code", {30'd0, bus_siz}, {30'd0, enc(r)});
            chk("R3 R5", "cycle address", bus_addr, a);
            chk("R11", "direction", {31'd0, bus_rw}, wr ? 32'd0 : 32'd1);
            for (int w = 0; w < waits; w++) begin
                if (w == 0) begin
                    // R10: request while busy must be ignored
                    req_valid = 1'b1; req_addr = 32'hFFFF_FFF1; req_size = 2'b01;
                    req_write = !wr;  req_wdata = ~wd;
                end
                bus_ack = 2'b00;
                @(negedge clk);
                req_valid = 1'b0;
                chk("R4", "strobe held in wait", {31'd0, bus_strobe}, 32'd1);
                chk("R4", "address held in wait", bus_addr, a);
                chk("R10", "address after busy request", bus_addr, a);
                chk("R9", "no done while waiting", {31'd0, done}, 32'd0);
            end
            lb  = int'(a[1:0]) % pw;
            acc = pw - lb;
            if (acc > r) acc = r;
            din = 32'hEEEE_EEEE;
            for (int i = 0; i < acc; i++) begin
                if (wr) begin
                    chk("R6", "write lane", {24'd0, bus_dout[8*(3-lb-i) +: 8]},
                        {24'd0, wd[8*(n-1-j-i) +: 8]});
                end else begin
                    din[8*(3-lb-i) +: 8] = mem_byte(a + i);
                end
                expr = (expr << 8) | {24'd0, mem_byte(a + i)};
            end
            bus_din = din;
            bus_ack = (pw == 4) ? 2'b11 : (pw == 2) ? 2'b10 : 2'b01;
            @(negedge clk);
            bus_ack = 2'b00;
            bus_din = 32'h0BAD_F00D;
            a = a + acc; r = r - acc; j = j + acc;
            chk("R8", "strobe low after ack", {31'd0, bus_strobe}, 32'd0);
            if (r == 0) begin
                chk("R9", "done after final ack", {31'd0, done}, 32'd1);
                if (!wr) chk("R7", "read operand", rd_data, expr);
            end else begin
                chk("R9", "no done mid transfer", {31'd0, done}, 32'd0);
                chk("R3", "address held in gap", bus_addr, a);
                @(negedge clk);
            end
        end
        @(negedge clk);
        chk("R9", "done single cycle", {31'd0, done}, 32'd0);
        chk("R8", "idle after transfer", {31'd0, bus_strobe}, 32'd0);
        if (!wr) chk("R9", "read operand held", rd_data, expr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL all watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(negedge clk);
        chk("R1", "strobe in reset", {31'd0, bus_strobe}, 32'd0);
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobe after reset", {31'd0, bus_strobe}, 32'd0);
        chk("R1", "done after reset", {31'd0, done}, 32'd0);

        // R6 R2: aligned long word write to a 16-bit port splits into 2 cycles
        run_xfer(2, 4, 0, 1'b1, 0);

        for (int pw = 1; pw <= 4; pw = pw * 2) begin
            for (int n = 1; n <= 4; n++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int d = 0; d < 2; d++) begin
                        run_xfer(pw, n, off, d[0], idx % 3);
                        idx++;
                    end
                end
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule